// File: doc/BRIEF.md
# Shifter Operand Generator with Carry-Out

This block produces the second operand of a 32-bit data-processing datapath together with the carry that logical operations write back to the flags. It takes a source register value and one of three operand sources: a shift by a 5-bit amount held in the instruction, a shift by an 8-bit amount read from another register, or an 8-bit constant rotated right by an even count. Four shift kinds are supported: left logical, right logical, right arithmetic and rotate right. The block is purely combinational. It has no clock, no state and no handshake. The result is valid in the same cycle as the inputs.

The encoding reuses a zero in the instruction amount to mean something else for each kind. A zero right shift means a shift by the full width, and a zero rotate means a one-bit rotate through the carry. Register-supplied amounts can exceed the data width, and each kind then has its own result and carry rule. The block also raises a flag whenever the amount comes from a register, so the pipeline can insert the extra cycle that the register read costs. Any program-counter offset on the source value is applied upstream.

Top module: `bsh_operand_gen`

## Requirements
- R1: `shift_kind` encodes 0 = left logical, 1 = right logical, 2 = right arithmetic, 3 = rotate right. `src_mode` encodes 0 = instruction amount, 1 = register amount, 2 = rotated constant, and 3 behaves exactly like 0. In `imm_field`, bits 11:8 are the rotate count and bits 7:0 are the constant.
- R2: In instruction-amount mode, a left shift by 0 returns `rm_value` unchanged, and `carry_out` equals `carry_in`.
- R3: In instruction-amount mode, a right logical shift by 0 acts as a shift by 32. `operand` is 0 and `carry_out` is `rm_value[31]`.
- R4: In instruction-amount mode, a right arithmetic shift by 0 acts as a shift by 32. Every bit of `operand` and `carry_out` equal `rm_value[31]`.
- R5: In instruction-amount mode, a rotate by 0 is a one-bit rotate through the carry. `operand` = {`carry_in`, `rm_value[31:1]`} and `carry_out` = `rm_value[0]`.
- R6: In register-amount mode, the whole 8-bit `reg_amount` is the amount. An amount of 0 returns `rm_value` unchanged with `carry_out` = `carry_in`, for every kind.
- R7: In register-amount mode, a left or right logical shift by exactly 32 gives `operand` 0 with `carry_out` = `rm_value[0]` (left) or `rm_value[31]` (right). Above 32, both `operand` and `carry_out` are 0.
- R8: In register-amount mode, a right arithmetic shift by 32 or more fills `operand` with `rm_value[31]`, and `carry_out` also equals `rm_value[31]`.
- R9: In register-amount mode, a rotate uses `reg_amount[4:0]`. A nonzero amount whose low five bits are 0 returns `rm_value` unchanged with `carry_out` = `rm_value[31]`.
- R10: In rotated-constant mode, the constant is zero-extended and rotated right by twice the rotate count. `carry_out` is `carry_in` when the count is 0 and `operand[31]` otherwise.
- R11: For in-range nonzero amounts n, `carry_out` is the last bit shifted out: `rm_value[32-n]` for a left shift, and `rm_value[n-1]` for right shifts and rotates.
- R12: `extra_cycle` is 1 exactly when `src_mode` selects register amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rm_value | input | 32 | Source register value |
| shift_kind | input | 2 | Shift kind select |
| src_mode | input | 2 | Operand source select |
| imm_amount | input | 5 | Shift amount from the instruction |
| reg_amount | input | 8 | Shift amount read from a register |
| imm_field | input | 12 | Rotate count and 8-bit constant |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Generated operand |
| carry_out | output | 1 | Shifter carry-out |
| extra_cycle | output | 1 | Register-supplied amount in use |

## Verification
The block holds no state, so a decode fault shows at the ports in the same evaluation as the stimulus that exposes it. Such a fault would be a zero amount decoded as a plain shift, or an out-of-range amount wrapping instead of saturating. The symptom is a wrong operand bit or a wrong carry for one specific kind and amount. For that reason the stimulus targets each special amount per kind: zero, exactly 32, above 32, and rotates whose low five bits are zero. Sweeps over every in-range amount catch a misrouted rotator stage or an off-by-one carry tap.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    SRC_IMM_SHIFT = 2'd0,
    SRC_REG_SHIFT = 2'd1,
    SRC_ROT_CONST = 2'd2,
    SRC_IMM_ALT   = 2'd3
  } src_mode_e;

  // Resolved action after amount decoding
  typedef enum logic [2:0] {
    ACT_PASS   = 3'd0,
    ACT_RRX    = 3'd1,
    ACT_FLUSH  = 3'd2,
    ACT_ROTATE = 3'd3,
    ACT_LINEAR = 3'd4
  } action_e;

endpackage

// File: rtl/bsh_amount_decode.sv
module bsh_amount_decode
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int NW    = SH_W + 1
) (
  input  shift_kind_e          kind,
  input  src_mode_e            mode,
  input  logic [SH_W-1:0]      imm_amt,
  input  logic [AMT_W-1:0]     reg_amt,
  output action_e              act,
  output logic [NW-1:0]        amt_n
);

  localparam logic [AMT_W:0] FULL_WIDE = (AMT_W+1)'(DATA_W);
  localparam logic [NW-1:0]  FULL_N    = NW'(DATA_W);

  logic reg_above;
  logic reg_at_least;
  logic reg_zero;
  logic imm_zero;

  always_comb begin
    reg_above    = {1'b0, reg_amt} >  FULL_WIDE;
    reg_at_least = {1'b0, reg_amt} >= FULL_WIDE;
    reg_zero     = (reg_amt == '0);
    imm_zero     = (imm_amt == '0);
  end

  always_comb begin
    act   = ACT_PASS;
    amt_n = '0;
    unique case (mode)
      SRC_REG_SHIFT: begin
        if (reg_zero) begin
          act = ACT_PASS;
        end else begin
          unique case (kind)
            SK_LSL, SK_LSR: begin
              if (reg_above) begin
                act = ACT_FLUSH;
              end else begin
                act   = ACT_LINEAR;
                amt_n = reg_amt[NW-1:0];
              end
            end
            SK_ASR: begin
              act   = ACT_LINEAR;
              amt_n = reg_at_least ? FULL_N : reg_amt[NW-1:0];
            end
            default: begin
              act   = ACT_ROTATE;
              amt_n = {1'b0, reg_amt[SH_W-1:0]};
            end
          endcase
        end
      end
      SRC_ROT_CONST: begin
        act = ACT_PASS;
      end
      default: begin
        if (imm_zero) begin
          unique case (kind)
            SK_LSL: act = ACT_PASS;
            SK_ROR: act = ACT_RRX;
            default: begin
              act   = ACT_LINEAR;
              amt_n = FULL_N;
            end
          endcase
        end else begin
          act   = (kind == SK_ROR) ? ACT_ROTATE : ACT_LINEAR;
          amt_n = {1'b0, imm_amt};
        end
      end
    endcase
  end

endmodule

// File: rtl/bsh_linear.sv
module bsh_linear
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NW    = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] din,
  input  shift_kind_e       kind,
  input  logic [NW-1:0]     amt_n,
  output logic [DATA_W-1:0] dout,
  output logic              cout
);

  // One guard bit beside the data catches the last bit shifted out.
  logic [DATA_W:0]        left_w;
  logic [DATA_W:0]        right_w;
  logic signed [DATA_W:0] arith_w;

  always_comb begin
    left_w  = {1'b0, din} << amt_n;
    right_w = {din, 1'b0} >> amt_n;
    arith_w = $signed({din, 1'b0}) >>> amt_n;
  end

  always_comb begin
    unique case (kind)
      SK_LSL: begin
        dout = left_w[DATA_W-1:0];
        cout = left_w[DATA_W];
      end
      SK_LSR: begin
        dout = right_w[DATA_W:1];
        cout = right_w[0];
      end
      SK_ASR: begin
        dout = arith_w[DATA_W:1];
        cout = arith_w[0];
      end
      default: begin
        dout = din;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bsh_rotr.sv
module bsh_rotr #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    assign stage[g+1] = amt[g]
                      ? {stage[g][STEP-1:0], stage[g][DATA_W-1:STEP]}
                      : stage[g];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/bsh_operand_gen.sv
module bsh_operand_gen
  import bsh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int CONST_W   = 8,
  parameter int ROTCNT_W  = 4,
  localparam int SH_W     = $clog2(DATA_W),
  localparam int NW       = SH_W + 1,
  localparam int FIELD_W  = CONST_W + ROTCNT_W
) (
  input  logic [DATA_W-1:0]  rm_value,
  input  logic [1:0]         shift_kind,
  input  logic [1:0]         src_mode,
  input  logic [SH_W-1:0]    imm_amount,
  input  logic [AMT_W-1:0]   reg_amount,
  input  logic [FIELD_W-1:0] imm_field,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  operand,
  output logic               carry_out,
  output logic               extra_cycle
);

  shift_kind_e kind;
  src_mode_e   mode;
  action_e     act;
  logic [NW-1:0] amt_n;

  assign kind = shift_kind_e'(shift_kind);
  assign mode = src_mode_e'(src_mode);

  bsh_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
    .kind    (kind),
    .mode    (mode),
    .imm_amt (imm_amount),
    .reg_amt (reg_amount),
    .act     (act),
    .amt_n   (amt_n)
  );

  logic [DATA_W-1:0] lin_out;
  logic              lin_c;

  bsh_linear #(.DATA_W(DATA_W)) u_linear (
    .din   (rm_value),
    .kind  (kind),
    .amt_n (amt_n),
    .dout  (lin_out),
    .cout  (lin_c)
  );

  logic [DATA_W-1:0] reg_rot;

  bsh_rotr #(.DATA_W(DATA_W)) u_rot_reg (
    .din  (rm_value),
    .amt  (amt_n[SH_W-1:0]),
    .dout (reg_rot)
  );

  logic [ROTCNT_W-1:0] rot_cnt;
  logic [DATA_W-1:0]   const_ext;
  logic [SH_W-1:0]     const_amt;
  logic [DATA_W-1:0]   const_rot;

  assign rot_cnt   = imm_field[FIELD_W-1:CONST_W];
  assign const_ext = DATA_W'(imm_field[CONST_W-1:0]);
  assign const_amt = SH_W'({rot_cnt, 1'b0});

  bsh_rotr #(.DATA_W(DATA_W)) u_rot_const (
    .din  (const_ext),
    .amt  (const_amt),
    .dout (const_rot)
  );

  always_comb begin
    extra_cycle = (mode == SRC_REG_SHIFT);
    if (mode == SRC_ROT_CONST) begin
      operand   = const_rot;
      carry_out = (rot_cnt == '0) ? carry_in : const_rot[DATA_W-1];
    end else begin
      unique case (act)
        ACT_PASS: begin
          operand   = rm_value;
          carry_out = carry_in;
        end
        ACT_RRX: begin
          operand   = {carry_in, rm_value[DATA_W-1:1]};
          carry_out = rm_value[0];
        end
        ACT_FLUSH: begin
          operand   = '0;
          carry_out = 1'b0;
        end
        ACT_ROTATE: begin
          operand   = reg_rot;
          carry_out = reg_rot[DATA_W-1];
        end
        default: begin
          operand   = lin_out;
          carry_out = lin_c;
        end
      endcase
    end
  end

endmodule

// File: rtl/bsh_operand_gen_chk.sv
module bsh_operand_gen_chk #(
  parameter int DATA_W   = 32,
  parameter int AMT_W    = 8,
  parameter int FIELD_W  = 12,
  parameter int CONST_W  = 8,
  localparam int SH_W    = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  rm_value,
  input logic [1:0]         shift_kind,
  input logic [1:0]         src_mode,
  input logic [SH_W-1:0]    imm_amount,
  input logic [AMT_W-1:0]   reg_amount,
  input logic [FIELD_W-1:0] imm_field,
  input logic               carry_in,
  input logic [DATA_W-1:0]  operand,
  input logic               carry_out,
  input logic               extra_cycle
);

  localparam logic [AMT_W:0] FULL = (AMT_W+1)'(DATA_W);

  logic imm_mode;
  logic reg_mode;
  assign imm_mode = (src_mode == 2'd0) || (src_mode == 2'd3);
  assign reg_mode = (src_mode == 2'd1);

  always_comb begin
    if (imm_mode && shift_kind == 2'd0 && imm_amount == '0)
      assert_imm_lsl_zero_R2: assert (operand == rm_value && carry_out == carry_in)
        else $error("R2 pass-through violated");
    if (imm_mode && shift_kind == 2'd1 && imm_amount == '0)
      assert_imm_lsr_full_R3: assert (operand == '0 && carry_out == rm_value[DATA_W-1])
        else $error("R3 full right shift violated");
    if (imm_mode && shift_kind == 2'd3 && imm_amount == '0)
      assert_rrx_R5: assert (operand == {carry_in, rm_value[DATA_W-1:1]} && carry_out == rm_value[0])
        else $error("R5 rotate through carry violated");
    if (reg_mode && reg_amount == '0)
      assert_reg_zero_R6: assert (operand == rm_value && carry_out == carry_in)
        else $error("R6 zero register amount violated");
    if (reg_mode && shift_kind[1] == 1'b0 && {1'b0, reg_amount} > FULL)
      assert_reg_flush_R7: assert (operand == '0 && carry_out == 1'b0)
        else $error("R7 over-range flush violated");
    if (reg_mode && shift_kind == 2'd2 && {1'b0, reg_amount} >= FULL)
      assert_reg_asr_sign_R8: assert (operand == {DATA_W{rm_value[DATA_W-1]}} && carry_out == rm_value[DATA_W-1])
        else $error("R8 sign fill violated");
    if (reg_mode && shift_kind == 2'd3 && reg_amount != '0)
      assert_reg_ror_carry_R9: assert (carry_out == operand[DATA_W-1])
        else $error("R9 rotate carry violated");
    if (src_mode == 2'd2 && imm_field[FIELD_W-1:CONST_W] != '0)
      assert_const_carry_R10: assert (carry_out == operand[DATA_W-1])
        else $error("R10 constant carry violated");
    assert_extra_cycle_R12: assert (extra_cycle == reg_mode)
      else $error("R12 extra cycle flag violated");
  end

endmodule

bind bsh_operand_gen bsh_operand_gen_chk #(
  .DATA_W  (DATA_W),
  .AMT_W   (AMT_W),
  .FIELD_W (FIELD_W),
  .CONST_W (CONST_W)
) u_chk (
  .rm_value    (rm_value),
  .shift_kind  (shift_kind),
  .src_mode    (src_mode),
  .imm_amount  (imm_amount),
  .reg_amount  (reg_amount),
  .imm_field   (imm_field),
  .carry_in    (carry_in),
  .operand     (operand),
  .carry_out   (carry_out),
  .extra_cycle (extra_cycle)
);

// File: tb/test_bsh_operand_gen.sv
module test_bsh_operand_gen;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] rm_value;
  logic [1:0]  shift_kind;
  logic [1:0]  src_mode;
  logic [4:0]  imm_amount;
  logic [7:0]  reg_amount;
  logic [11:0] imm_field;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out;
  logic        extra_cycle;

  bsh_operand_gen i_bsh_operand_gen (
    .rm_value    (rm_value),
    .shift_kind  (shift_kind),
    .src_mode    (src_mode),
    .imm_amount  (imm_amount),
    .reg_amount  (reg_amount),
    .imm_field   (imm_field),
    .carry_in    (carry_in),
    .operand     (operand),
    .carry_out   (carry_out),
    .extra_cycle (extra_cycle)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Layout: mode, kind, imm5, reg8, field12, cin, rm, exp_op, exp_c, exp_x
  localparam int NV = 27;
  localparam logic [95:0] VEC [NV] = '{
    {2'd0,2'd0,5'd0, 8'd0,  12'h000,1'b1,32'h12345678,32'h12345678,1'b1,1'b0}, // R2
    {2'd0,2'd0,5'd4, 8'd0,  12'h000,1'b0,32'hF000000F,32'h000000F0,1'b1,1'b0}, // R11
    {2'd0,2'd1,5'd0, 8'd0,  12'h000,1'b0,32'h80000000,32'h00000000,1'b1,1'b0}, // R3
    {2'd0,2'd1,5'd8, 8'd0,  12'h000,1'b0,32'h000001FF,32'h00000001,1'b1,1'b0}, // R11
    {2'd0,2'd2,5'd0, 8'd0,  12'h000,1'b0,32'h80000000,32'hFFFFFFFF,1'b1,1'b0}, // R4
    {2'd0,2'd2,5'd0, 8'd0,  12'h000,1'b1,32'h7FFFFFFF,32'h00000000,1'b0,1'b0}, // R4
    {2'd0,2'd2,5'd4, 8'd0,  12'h000,1'b0,32'h80000010,32'hF8000001,1'b0,1'b0}, // R11
    {2'd0,2'd3,5'd0, 8'd0,  12'h000,1'b1,32'h00000003,32'h80000001,1'b1,1'b0}, // R5
    {2'd0,2'd3,5'd0, 8'd0,  12'h000,1'b0,32'h00000002,32'h00000001,1'b0,1'b0}, // R5
    {2'd0,2'd3,5'd8, 8'd0,  12'h000,1'b0,32'h000000A5,32'hA5000000,1'b1,1'b0}, // R11
    {2'd1,2'd0,5'd7, 8'd0,  12'h000,1'b1,32'hDEADBEEF,32'hDEADBEEF,1'b1,1'b1}, // R6
    {2'd1,2'd0,5'd0, 8'd32, 12'h000,1'b0,32'h00000001,32'h00000000,1'b1,1'b1}, // R7
    {2'd1,2'd0,5'd0, 8'd33, 12'h000,1'b1,32'hFFFFFFFF,32'h00000000,1'b0,1'b1}, // R7
    {2'd1,2'd1,5'd0, 8'd32, 12'h000,1'b0,32'h80000000,32'h00000000,1'b1,1'b1}, // R7
    {2'd1,2'd1,5'd0, 8'd255,12'h000,1'b1,32'hFFFFFFFF,32'h00000000,1'b0,1'b1}, // R7
    {2'd1,2'd1,5'd0, 8'd1,  12'h000,1'b0,32'h00000003,32'h00000001,1'b1,1'b1}, // R11
    {2'd1,2'd2,5'd0, 8'd32, 12'h000,1'b0,32'h80000000,32'hFFFFFFFF,1'b1,1'b1}, // R8
    {2'd1,2'd2,5'd0, 8'd200,12'h000,1'b1,32'h40000000,32'h00000000,1'b0,1'b1}, // R8
    {2'd1,2'd3,5'd0, 8'd32, 12'h000,1'b0,32'h80000001,32'h80000001,1'b1,1'b1}, // R9
    {2'd1,2'd3,5'd0, 8'h44, 12'h000,1'b0,32'h0000000F,32'hF0000000,1'b1,1'b1}, // R9
    {2'd1,2'd3,5'd0, 8'd32, 12'h000,1'b1,32'h00000001,32'h00000001,1'b0,1'b1}, // R9
    {2'd2,2'd1,5'd3, 8'd9,  12'h0FF,1'b1,32'h00000000,32'h000000FF,1'b1,1'b0}, // R10
    {2'd2,2'd0,5'd0, 8'd0,  12'h4FF,1'b0,32'h11111111,32'hFF000000,1'b1,1'b0}, // R10
    {2'd2,2'd0,5'd0, 8'd0,  12'h102,1'b0,32'h00000000,32'h80000000,1'b1,1'b0}, // R10
    {2'd2,2'd0,5'd0, 8'd0,  12'h204,1'b1,32'h00000000,32'h40000000,1'b0,1'b0}, // R10
    {2'd3,2'd1,5'd0, 8'd0,  12'h000,1'b0,32'h80000000,32'h00000000,1'b1,1'b0}, // R1
    {2'd1,2'd0,5'd0, 8'd31, 12'h000,1'b0,32'h00000003,32'h80000000,1'b1,1'b1}  // R11
  };
  localparam int VREQ [NV] = '{2,11,3,11,4,4,11,5,5,11,6,7,7,7,7,11,8,8,9,9,9,10,10,10,10,1,11};

  task automatic apply(input logic [1:0] m, input logic [1:0] k, input logic [4:0] ia,
                       input logic [7:0] ra, input logic [11:0] f, input logic c,
                       input logic [31:0] r);
    @(posedge clk);
    src_mode = m; shift_kind = k; imm_amount = ia; reg_amount = ra;
    imm_field = f; carry_in = c; rm_value = r;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] eop, input logic ec, input logic ex);
    checks++;
    if (operand !== eop || carry_out !== ec || extra_cycle !== ex) begin
      errors++;
      $display("FAIL %s: got op=%h c=%b x=%b, expected op=%h c=%b x=%b",
               req, operand, carry_out, extra_cycle, eop, ec, ex);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rm_value = '0; shift_kind = '0; src_mode = '0; imm_amount = '0;
    reg_amount = '0; imm_field = '0; carry_in = 1'b0;
    @(negedge clk);
    // Idle state: all-zero inputs give a zero operand, no carry, no extra cycle (R2, R12)
    check("R2 idle", 32'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      v = VEC[i];
      apply(v[95:94], v[93:92], v[91:87], v[86:79], v[78:67], v[66], v[65:34]);
      check($sformatf("R%0d vector %0d", VREQ[i], i), v[33:2], v[1], v[0]);
    end

    // R11 sweep: left shift by every in-range instruction amount
    for (int n = 1; n < 32; n++) begin
      logic [31:0] r;
      r = 32'hA53C_96E1;
      apply(2'd0, 2'd0, 5'(n), 8'd0, 12'h000, 1'b0, r);
      check($sformatf("R11 lsl n=%0d", n), r << n, r[32-n], 1'b0);
    end

    // R9 sweep: register rotate by every in-range amount, high bits set to be ignored
    for (int n = 1; n < 32; n++) begin
      logic [31:0] r;
      logic [31:0] e;
      r = 32'h0F1E_2D3C;
      e = (r >> n) | (r << (32 - n));
      apply(2'd1, 2'd3, 5'd0, 8'(n) | 8'hE0, 12'h000, 1'b0, r);
      check($sformatf("R9 ror n=%0d", n), e, r[n-1], 1'b1);
    end

    // R12: register mode with zero amount still requests the extra cycle
    apply(2'd1, 2'd2, 5'd5, 8'd0, 12'h000, 1'b0, 32'h8000_0000);
    check("R12 zero reg amount", 32'h8000_0000, 1'b0, 1'b1);

    // R6: instruction amount is ignored in register mode
    apply(2'd1, 2'd1, 5'd31, 8'd4, 12'hFFF, 1'b0, 32'h0000_00F0);
    check("R6 imm amount ignored", 32'h0000_000F, 1'b0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule